// File: doc/BRIEF.md
# Serial-frame single-wire bus host

This block is the host end of a single-wire, open-drain sensor bus. It does not drive bus timing itself. Each reset pulse and each bit slot is produced by sending one asynchronous serial character on `txd`. An external push-pull to open-drain stage and pull-up join `txd` to the bus wire. The same wire is tied back to `rxd`. What comes back on `rxd` is the transmitted character with any device pull-downs overlaid, and the block decodes that echo by comparing it with fixed byte patterns.

Software or a higher-level engine issues one operation at a time through a valid/ready command port: a bus reset with presence detect, a byte write, or a byte read. Each operation ends with exactly one response beat that carries a byte, a presence flag and a framing-error flag. A speed input picks standard or overdrive timing. The character rate differs between reset slots and data slots, and the baud divider is switched only while the transmit line rests high.

Top module: `swire_uart_host`

## Requirements
- R1: Every slot is one 8-N-1 character on `txd`: a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts exactly one divider period. `txd` is high whenever no character is in flight.
- R2: A bus reset (`cmd_op` = 0) sends the character 0x00, so the line stays low for nine bit periods. It uses the reset rate: round(CLK_HZ/18750) clocks per bit at standard speed (`speed_fast` = 0) and round(CLK_HZ/187500) at overdrive (`speed_fast` = 1).
- R3: After a reset, `rsp_present` is 1 when the echoed character is 0xFC or 0xFE and 0 for any other value, and `rsp_data` carries the raw echoed character. `rsp_present` is 0 for every other operation.
- R4: Write and read slots use the data rate: round(CLK_HZ/115200) clocks per bit at standard speed and round(CLK_HZ/500000) at overdrive.
- R5: A byte write (`cmd_op` = 1) sends eight slots, least significant bit first. A 0 bit sends 0xC0, so the line is low for seven bit periods, and a 1 bit sends 0xFF. The response returns the byte that was written.
- R6: A byte read (`cmd_op` = 2 or 3) sends 0xFF in each of eight slots. An echo of 0xFC or 0xF8 decodes as 0, and an echo of 0xFF or 0xFE decodes as 1. The eight decoded bits are assembled least significant first into `rsp_data`.
- R7: During a read, an echo outside those four values sets `rsp_ferr`, and that bit is reported as 1.
- R8: An echo whose stop bit is sampled low sets `rsp_ferr` for the operation in progress, whatever the operation is.
- R9: A slot starts only after the echo's stop bit has been sampled and the transmitted stop bit has finished, so `txd` stays high across the whole stop bit of every character.
- R10: The baud divider changes value only while the transmitter is idle. Switching speed or slot type between operations therefore takes effect cleanly on the next character.
- R11: `cmd_ready` is high only when no operation is active, and `rsp_valid` and `cmd_ready` are never high together. `rsp_valid` and the response fields stay stable until `rsp_ready` is seen. After reset, `txd` = 1, `cmd_ready` = 1 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed_fast | input | 1 | 1 = overdrive timing, 0 = standard timing; sampled with the command |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and accepting a command |
| cmd_op | input | 2 | 0 = bus reset, 1 = write byte, 2 or 3 = read byte |
| cmd_data | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 8 | Read byte, written byte, or raw reset echo |
| rsp_present | output | 1 | Presence seen after a bus reset |
| rsp_ferr | output | 1 | Framing error or undecodable echo during the operation |
| txd | output | 1 | Serial transmit line, high when idle |
| rxd | input | 1 | Serial receive line carrying the bus echo |

## Verification
On every cycle, the embedded assertions check the handshake rules: ready and valid are exclusive, and a pending response is held stable. They also check that the divider only moves while the transmitter is idle, that no slot launches while either serial engine is busy, that each character begins with a low start bit, and that presence is only ever reported for a reset. Some properties can only be shown by the bench's scenarios, because the bench plays the devices on the echo line. These are the exact low-time of each character, which proves the divider rounding and the rate switch between reset and data slots. They also include the pattern decode of every echo value, the bit order of assembled bytes, and the error flag raised for bad patterns and low stop bits.

// File: rtl/swu_pkg.sv
package swu_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_READX = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SLOT,
    S_WAIT,
    S_RESP
  } seq_e;

  localparam logic [7:0] CH_RESET = 8'h00;
  localparam logic [7:0] CH_ZERO  = 8'hC0;
  localparam logic [7:0] CH_ONE   = 8'hFF;

  function automatic int div_round(input int clk_hz, input int baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // {undecodable, bit}
  function automatic logic [1:0] read_decode(input logic [7:0] echo);
    logic [1:0] r;
    case (echo)
      8'hFC, 8'hF8: r = 2'b00;
      8'hFF, 8'hFE: r = 2'b01;
      default:      r = 2'b11;
    endcase
    return r;
  endfunction

  function automatic logic presence_seen(input logic [7:0] echo);
    return (echo == 8'hFC) || (echo == 8'hFE);
  endfunction

endpackage

// File: rtl/swu_baud.sv
module swu_baud #(
  parameter int D_STD_RST = 5333,
  parameter int D_STD_BIT = 868,
  parameter int D_OD_RST  = 533,
  parameter int D_OD_BIT  = 200,
  parameter int DIV_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_busy,
  input  logic             fast,
  input  logic             reset_slot,
  output logic [DIV_W-1:0] div
);
  logic [DIV_W-1:0] div_q, div_d, sel;

  always_comb begin
    case ({fast, reset_slot})
      2'b01:   sel = DIV_W'(D_STD_RST);
      2'b00:   sel = DIV_W'(D_STD_BIT);
      2'b11:   sel = DIV_W'(D_OD_RST);
      default: sel = DIV_W'(D_OD_BIT);
    endcase
    div_d = tx_busy ? div_q : sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= DIV_W'(D_STD_RST);
    else        div_q <= div_d;
  end

  assign div = div_q;

  // R10: divider only moves when the transmitter was idle
  p_div_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(!tx_busy));
endmodule

// File: rtl/swu_tx.sv
module swu_tx #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [DIV_W-1:0] div,
  output logic             txd,
  output logic             busy,
  output logic             done
);
  logic             busy_q, busy_d, done_q, done_d;
  logic [9:0]       sh_q, sh_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [3:0]       bit_q, bit_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data, 1'b0};
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (cnt_q == div - 1'b1) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[9:1]};
      if (bit_q == 4'd9) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d = bit_q + 4'd1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
    end
  end

  assign txd  = !busy_q || sh_q[0];
  assign busy = busy_q;
  assign done = done_q;

  // R1: a character opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
  // R1: ten bits per character, never more
  p_bit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q <= 4'd9));
endmodule

// File: rtl/swu_rx.sv
module swu_rx #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic [7:0]       data,
  output logic             stop_bad
);
  logic             s1_q, s2_q, prev_q;
  logic             busy_q, busy_d, done_q, done_d, sbad_q, sbad_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             fall;

  assign fall = prev_q && !s2_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    sbad_d = sbad_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (fall) begin
        busy_d = 1'b1;
        cnt_d  = div >> 1;
        bit_d  = '0;
      end
    end else if (cnt_q == '0) begin
      cnt_d = div - 1'b1;
      if (bit_q == 4'd9) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        sbad_d = !s2_q;
      end else begin
        if (bit_q != 4'd0) sh_d = {s2_q, sh_q[7:1]};
        bit_d = bit_q + 4'd1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sbad_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      busy_q <= busy_d;
      done_q <= done_d;
      sbad_q <= sbad_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign data     = sh_q;
  assign stop_bad = sbad_q;

  // R9: completion is a single-cycle event
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/swire_uart_host.sv
module swire_uart_host #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int STD_RST_BAUD = 18750,
  parameter int STD_BIT_BAUD = 115200,
  parameter int OD_RST_BAUD  = 187500,
  parameter int OD_BIT_BAUD  = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_fast,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_present,
  output logic       rsp_ferr,
  output logic       txd,
  input  logic       rxd
);
  import swu_pkg::*;

  localparam int D_SR  = div_round(CLK_HZ, STD_RST_BAUD);
  localparam int D_SB  = div_round(CLK_HZ, STD_BIT_BAUD);
  localparam int D_OR  = div_round(CLK_HZ, OD_RST_BAUD);
  localparam int D_OB  = div_round(CLK_HZ, OD_BIT_BAUD);
  localparam int D_MAX = max2(max2(D_SR, D_SB), max2(D_OR, D_OB));
  localparam int DIV_W = $clog2(D_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  seq_e       st_q, st_d;
  op_e        op_q, op_d;
  logic       fast_q, fast_d, txs_q, txs_d, rxs_q, rxs_d;
  logic       pres_q, pres_d, ferr_q, ferr_d;
  logic [7:0] data_q, data_d, tx_byte, rx_byte;
  logic [2:0] slot_q, slot_d;
  logic       tx_start, tx_busy, tx_done, rx_busy, rx_done, rx_sbad;
  logic       shin;
  logic [1:0] rdec;
  logic [DIV_W-1:0] div;

  swu_baud #(.D_STD_RST(D_SR), .D_STD_BIT(D_SB), .D_OD_RST(D_OR),
             .D_OD_BIT(D_OB), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(srst_n), .tx_busy(tx_busy), .fast(fast_q),
    .reset_slot(op_q == OP_RESET), .div(div));

  swu_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(srst_n), .start(tx_start), .data(tx_byte), .div(div),
    .txd(txd), .busy(tx_busy), .done(tx_done));

  swu_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(srst_n), .rxd(rxd), .div(div), .busy(rx_busy),
    .done(rx_done), .data(rx_byte), .stop_bad(rx_sbad));

  assign tx_start = (st_q == S_SLOT);
  assign tx_byte  = (op_q == OP_RESET) ? CH_RESET :
                    ((op_q == OP_WRITE) && !data_q[0]) ? CH_ZERO : CH_ONE;
  assign rdec     = read_decode(rx_byte);

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    fast_d = fast_q;
    data_d = data_q;
    slot_d = slot_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    pres_d = pres_q;
    ferr_d = ferr_q;
    shin   = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        st_d   = S_SLOT;
        op_d   = op_e'(cmd_op);
        fast_d = speed_fast;
        data_d = cmd_data;
        slot_d = '0;
        pres_d = 1'b0;
        ferr_d = 1'b0;
      end
      S_SLOT: begin
        st_d  = S_WAIT;
        txs_d = 1'b0;
        rxs_d = 1'b0;
      end
      S_WAIT: begin
        if (tx_done) txs_d = 1'b1;
        if (rx_done) rxs_d = 1'b1;
        if ((txs_q || tx_done) && (rxs_q || rx_done)) begin
          if (rx_sbad) ferr_d = 1'b1;
          if (op_q == OP_RESET) begin
            pres_d = presence_seen(rx_byte);
            data_d = rx_byte;
            st_d   = S_RESP;
          end else begin
            if (op_q == OP_WRITE) begin
              shin = data_q[0];
            end else begin
              shin = rdec[0];
              if (rdec[1]) ferr_d = 1'b1;
            end
            data_d = {shin, data_q[7:1]};
            slot_d = slot_q + 3'd1;
            st_d   = (slot_q == 3'd7) ? S_RESP : S_SLOT;
          end
        end
      end
      default: if (rsp_ready) st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_RESET;
      fast_q <= 1'b0;
      data_q <= '0;
      slot_q <= '0;
      txs_q  <= 1'b0;
      rxs_q  <= 1'b0;
      pres_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      fast_q <= fast_d;
      data_q <= data_d;
      slot_q <= slot_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      pres_q <= pres_d;
      ferr_q <= ferr_d;
    end
  end

  assign cmd_ready   = (st_q == S_IDLE);
  assign rsp_valid   = (st_q == S_RESP);
  assign rsp_data    = data_q;
  assign rsp_present = pres_q;
  assign rsp_ferr    = ferr_q;

  // R11: command and response sides never open together
  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !(cmd_ready && rsp_valid));
  // R11: a pending response is held until taken
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
    $stable(rsp_present) && $stable(rsp_ferr));
  // R9: a slot launches only when both serial engines are quiet
  p_launch_quiet_r9: assert property (@(posedge clk) disable iff (!srst_n)
    tx_start |-> !tx_busy && !rx_busy && txd);
  // R3: presence only ever reported for a bus reset
  p_present_reset_r3: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid && rsp_present |-> op_q == OP_RESET);
endmodule

// File: tb/tb_swire_uart_host.sv
module tb_swire_uart_host;
  localparam int CLK_HZ = 4_000_000;  // scaled rate keeps frames short

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, speed_fast, cmd_valid, cmd_ready, rsp_valid, rsp_ready;
  logic       rsp_present, rsp_ferr, txd, rxd;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data, rsp_data;
  logic       rx_drv = 1'b1;
  assign rxd = rx_drv;

  swire_uart_host #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_present(rsp_present), .rsp_ferr(rsp_ferr), .txd(txd), .rxd(rxd));

  int total = 0;
  int bad   = 0;

  logic [7:0] echo_b [8];
  logic       echo_stop [8];
  logic [7:0] seen_b [8];
  int         seen_low [8];
  logic       seen_stop [8];
  int         mon_div = 8;
  int         mon_idx = 0;

  function automatic int exp_div(input bit fast, input bit rst);
    int b;
    b = rst ? (fast ? 187500 : 18750) : (fast ? 500000 : 115200);
    return (CLK_HZ + b / 2) / b;
  endfunction

  function automatic int low_bits(input logic [7:0] b);
    int n;
    bit go;
    n = 1;
    go = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (go && !b[i]) n++;
      else go = 1'b0;
    end
    return n;
  endfunction

  function automatic bit is_pat(input logic [7:0] e);
    return (e == 8'hFC) || (e == 8'hF8) || (e == 8'hFF) || (e == 8'hFE);
  endfunction

  function automatic logic dec_bit(input logic [7:0] e);
    return !((e == 8'hFC) || (e == 8'hF8));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model: plays the echo on rxd and records each transmitted frame
  initial begin
    logic       prev;
    int         d, idx, low, bitn;
    logic       inlow, stop_ok;
    logic [7:0] acc;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (prev && !txd) begin
        d = mon_div;
        idx = (mon_idx < 8) ? mon_idx : 7;
        low = 0; inlow = 1'b1; stop_ok = 1'b1; acc = '0;
        for (int k = 0; k < 10 * d; k++) begin
          if (k > 0) @(negedge clk);
          bitn = k / d;
          rx_drv = (bitn == 0) ? 1'b0 :
                   (bitn <= 8) ? echo_b[idx][bitn-1] : echo_stop[idx];
          if (inlow && !txd) low++;
          else inlow = 1'b0;
          if (bitn >= 1 && bitn <= 8 && (k % d) == d / 2) acc[bitn-1] = txd;
          if (bitn == 9 && !txd) stop_ok = 1'b0;
        end
        seen_b[idx] = acc;
        seen_low[idx] = low;
        seen_stop[idx] = stop_ok;
        mon_idx++;
        @(negedge clk);
        rx_drv = 1'b1;
      end
      prev = txd;
    end
  end

  task automatic clear_stops();
    for (int i = 0; i < 8; i++) echo_stop[i] = 1'b1;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] data,
                        input bit fast);
    logic [7:0] xb, xd, got_d;
    logic       xp, xf, got_p, got_f;
    int         nfr, dv;
    string      rq;
    dv = exp_div(fast, op == 2'd0);
    nfr = (op == 2'd0) ? 1 : 8;
    if (op == 2'd1)
      for (int i = 0; i < 8; i++) echo_b[i] = data[i] ? 8'hFF : 8'hC0;
    // expected response, from the requirements
    xp = 1'b0; xf = 1'b0; xd = '0;
    for (int i = 0; i < nfr; i++) if (!echo_stop[i]) xf = 1'b1;
    if (op == 2'd0) begin
      xp = (echo_b[0] == 8'hFC) || (echo_b[0] == 8'hFE);
      xd = echo_b[0];
    end else if (op == 2'd1) begin
      xd = data;
    end else begin
      for (int i = 0; i < 8; i++) begin
        xd[i] = dec_bit(echo_b[i]);
        if (!is_pat(echo_b[i])) xf = 1'b1;
      end
    end
    mon_div = dv;
    mon_idx = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data; speed_fast = fast;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", "ready low while busy", {31'd0, cmd_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    got_d = rsp_data; got_p = rsp_present; got_f = rsp_ferr;
    repeat (3) @(negedge clk);
    chk("R11", "response held", {22'd0, rsp_valid, cmd_ready, rsp_data},
        {22'd0, 1'b1, 1'b0, got_d});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11", "response released", {30'd0, rsp_valid, cmd_ready}, 32'd1);
    chk("R9", "frame count", mon_idx, nfr);
    for (int i = 0; i < nfr; i++) begin
      xb = (op == 2'd0) ? 8'h00 : (op == 2'd1 && !data[i]) ? 8'hC0 : 8'hFF;
      chk((op == 2'd1) ? "R5" : (op == 2'd0) ? "R2" : "R6", "slot character",
          {24'd0, seen_b[i]}, {24'd0, xb});
      chk((op == 2'd0) ? "R2" : "R4", "low time", seen_low[i], low_bits(xb) * dv);
      chk("R9", "stop bit high", {31'd0, seen_stop[i]}, 32'd1);
    end
    rq = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R5" : "R6";
    chk(rq, "rsp_data", {24'd0, got_d}, {24'd0, xd});
    chk("R3", "rsp_present", {31'd0, got_p}, {31'd0, xp});
    chk((op >= 2'd2 && xf && !(xf && echo_stop[0] == 1'b0)) ? "R7" : "R8",
        "rsp_ferr", {31'd0, got_f}, {31'd0, xf});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] op;
    logic [7:0] pats [4];
    pats[0] = 8'hFC; pats[1] = 8'hF8; pats[2] = 8'hFF; pats[3] = 8'hFE;
    void'($urandom(32'd4242));
    rst_n = 1'b0; speed_fast = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    cmd_data = '0; rsp_ready = 1'b0;
    clear_stops();
    for (int i = 0; i < 8; i++) echo_b[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "reset txd", {31'd0, txd}, 32'd1);
    chk("R11", "reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R11", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R2 R3: resets at both speeds with each echo class
    echo_b[0] = 8'hFC; run_op(2'd0, 8'h00, 1'b0);
    echo_b[0] = 8'hFE; run_op(2'd0, 8'h00, 1'b1);
    echo_b[0] = 8'hF0; run_op(2'd0, 8'h00, 1'b1);
    echo_b[0] = 8'h00; run_op(2'd0, 8'h00, 1'b1);
    // R8: reset echo with a low stop bit
    echo_b[0] = 8'hFC; echo_stop[0] = 1'b0; run_op(2'd0, 8'h00, 1'b1);
    clear_stops();
    // R4 R5: writes, speed switched between operations (R10)
    run_op(2'd1, 8'hA5, 1'b1);
    run_op(2'd1, 8'h3C, 1'b0);
    run_op(2'd1, 8'h00, 1'b1);
    // R6: reads using every valid pattern
    echo_b[0] = 8'hFC; echo_b[1] = 8'hFF; echo_b[2] = 8'hF8; echo_b[3] = 8'hFE;
    echo_b[4] = 8'hFE; echo_b[5] = 8'hF8; echo_b[6] = 8'hFF; echo_b[7] = 8'hFC;
    run_op(2'd2, 8'h00, 1'b1);
    run_op(2'd3, 8'h00, 1'b0);
    // R7: undecodable echo reads as 1 and flags
    echo_b[3] = 8'hE0; run_op(2'd2, 8'h00, 1'b1);
    // R8: write with a low echo stop bit in slot 5
    echo_stop[5] = 1'b0; run_op(2'd1, 8'h96, 1'b1);
    clear_stops();

    // constrained random mix
    for (int n = 0; n < 14; n++) begin
      op = 2'($urandom % 3);
      for (int i = 0; i < 8; i++) begin
        echo_b[i] = (($urandom % 16) == 0) ? 8'hE0 : pats[$urandom % 4];
        echo_stop[i] = (($urandom % 24) != 0);
      end
      if (op == 2'd0) begin
        case ($urandom % 4)
          0: echo_b[0] = 8'hFC;
          1: echo_b[0] = 8'hFE;
          2: echo_b[0] = 8'hF0;
          default: echo_b[0] = 8'h00;
        endcase
      end
      run_op(op, 8'($urandom), ($urandom % 4) != 0);
      clear_stops();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule